// File: doc/BRIEF.md
# Dual-Slope Time-to-Digital Controller

This block turns the width of a gate pulse into a digital code. An external integrator does the analog work. While the gate is high the block holds a charge enable so that a fast, constant current fills the capacitor. When the gate drops, the block switches to a slower constant discharge current and counts clock cycles until an external comparator reports that the capacitor has reached zero. Each count step is therefore worth the clock period times the ratio of discharge current to charge current. With a 500 ps clock and a current ratio of about 8.5 to 41.3, one step is close to 103 ps.

The count is 4 bits wide by default. It saturates instead of wrapping, and an overflow flag marks a measurement that hit the ceiling. Together with the code the block presents a time estimate: the code multiplied by a fixed-point constant per count. Code, estimate and overflow are registered together and announced by a one-cycle valid strobe. After a measurement, a new one is accepted only once the comparator has read zero for at least one idle cycle.

Top module: `dual_slope_tdc`

## Requirements
- R1: During reset and immediately after it, both enables are low, valid_o is 0, and code_o, time_o and ovf_o are 0.
- R2: When the block is idle and armed, charge_en_o rises in the cycle after the first clock edge that samples gate_i high. It stays high until the edge that samples gate_i low, so it is high for exactly as many cycles as gate_i was high.
- R3: charge_en_o and discharge_en_o are never high in the same cycle.
- R4: discharge_en_o rises at the same edge where charge_en_o falls. It stays high until the first edge that samples cap_pos_i low. code_o equals the number of discharge edges that sampled cap_pos_i high.
- R5: The count saturates at 2^CODE_W-1. A measurement that would exceed this reports code_o = 2^CODE_W-1 with ovf_o = 1. A measurement that reaches exactly 2^CODE_W-1 reports ovf_o = 0.
- R6: time_o equals code_o times STEP_Q, an unsigned value with FRAC_W fractional bits (default 1646, which is about 102.9 ps in steps of 1/16 ps).
- R7: valid_o is high for exactly one cycle per measurement, in the cycle after the discharge ends. code_o, time_o and ovf_o change only together with valid_o and hold their value otherwise.
- R8: A gate pulse is ignored, and charge_en_o stays low, unless cap_pos_i was sampled low in the idle state on the clock edge before the edge that samples gate_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Pulse whose width is measured |
| cap_pos_i | input | 1 | Comparator: integrator capacitor above zero |
| charge_en_o | output | 1 | Enables the fast charge current |
| discharge_en_o | output | 1 | Enables the slow discharge current |
| code_o | output | CODE_W | Discharge cycle count |
| time_o | output | CODE_W+STEP_W | Code times STEP_Q, fixed point |
| ovf_o | output | 1 | The count saturated |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The hardest cases to reach from the ports are the exact boundary of the count ceiling and a comparator that stays high while the block is idle, because both depend on the analog side. The bench includes a behavioural integrator whose charge and discharge currents it sets freely. It picks current pairs that land the count exactly on 15 and just above it, plus pairs that give a count of zero. A separate override holds the comparator high, so the bench can show that a gate pulse arriving in that state is ignored. Random gate widths and current ratios fill the space between these cases.

// File: rtl/dstdc_pkg.sv
package dstdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_DISCH  = 2'd2
  } tdc_state_e;
endpackage

// File: rtl/dstdc_arm.sv
module dstdc_arm
  import dstdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tdc_state_e state_i,
  input  logic       cap_pos_i,
  output logic       armed_o
);
  logic armed_q;

  // armed only after an idle cycle with an empty capacitor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (state_i == ST_IDLE) armed_q <= !cap_pos_i;
    else                        armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/dstdc_fsm.sv
module dstdc_fsm
  import dstdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gate_i,
  input  logic       cap_pos_i,
  input  logic       armed_i,
  output tdc_state_e state_o,
  output logic       clr_o,
  output logic       inc_o,
  output logic       done_o
);
  tdc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (armed_i && gate_i) state_d = ST_CHARGE;
      ST_CHARGE: if (!gate_i)           state_d = ST_DISCH;
      ST_DISCH:  if (!cap_pos_i)        state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign clr_o   = (state_q == ST_CHARGE) && !gate_i;
  assign inc_o   = (state_q == ST_DISCH) && cap_pos_i;
  assign done_o  = (state_q == ST_DISCH) && !cap_pos_i;
endmodule

// File: rtl/dstdc_counter.sv
module dstdc_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      if (cnt_q == CntMax) ovf_q <= 1'b1;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/dstdc_result.sv
module dstdc_result #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP_W = 16,
  parameter logic [STEP_W-1:0] STEP_Q = 1646,
  localparam int unsigned TIME_W = CODE_W + STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] cnt_i,
  input  logic              ovf_i,
  output logic [CODE_W-1:0] code_o,
  output logic [TIME_W-1:0] time_o,
  output logic              ovf_o,
  output logic              valid_o
);
  logic [TIME_W-1:0] time_d;
  logic [CODE_W-1:0] code_q;
  logic [TIME_W-1:0] time_q;
  logic              ovf_q, valid_q;

  assign time_d = TIME_W'(cnt_i) * TIME_W'(STEP_Q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      time_q  <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) begin
        code_q <= cnt_i;
        time_q <= time_d;
        ovf_q  <= ovf_i;
      end
    end
  end

  assign code_o  = code_q;
  assign time_o  = time_q;
  assign ovf_o   = ovf_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dual_slope_tdc.sv
module dual_slope_tdc
  import dstdc_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP_W = 16,
  parameter int unsigned FRAC_W = 4,
  parameter logic [STEP_W-1:0] STEP_Q = 1646,
  localparam int unsigned TIME_W = CODE_W + STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              cap_pos_i,
  output logic              charge_en_o,
  output logic              discharge_en_o,
  output logic [CODE_W-1:0] code_o,
  output logic [TIME_W-1:0] time_o,
  output logic              ovf_o,
  output logic              valid_o
);
  // FRAC_W documents the binary point of STEP_Q and time_o
  localparam int unsigned FracBits = FRAC_W;

  tdc_state_e        state;
  logic              armed, clr, inc, done;
  logic [CODE_W-1:0] cnt;
  logic              cnt_ovf;

  dstdc_arm u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .cap_pos_i(cap_pos_i),
    .armed_o  (armed)
  );

  dstdc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_i   (gate_i),
    .cap_pos_i(cap_pos_i),
    .armed_i  (armed),
    .state_o  (state),
    .clr_o    (clr),
    .inc_o    (inc),
    .done_o   (done)
  );

  dstdc_counter #(.W(CODE_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (cnt),
    .ovf_o (cnt_ovf)
  );

  dstdc_result #(
    .CODE_W(CODE_W),
    .STEP_W(STEP_W),
    .STEP_Q(STEP_Q)
  ) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done),
    .cnt_i  (cnt),
    .ovf_i  (cnt_ovf),
    .code_o (code_o),
    .time_o (time_o),
    .ovf_o  (ovf_o),
    .valid_o(valid_o)
  );

  assign charge_en_o    = (state == ST_CHARGE);
  assign discharge_en_o = (state == ST_DISCH);
endmodule

// File: rtl/dstdc_checker.sv
module dstdc_checker #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP_W = 16,
  parameter logic [STEP_W-1:0] STEP_Q = 1646,
  localparam int unsigned TIME_W = CODE_W + STEP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gate_i,
  input logic              cap_pos_i,
  input logic              charge_en_o,
  input logic              discharge_en_o,
  input logic [CODE_W-1:0] code_o,
  input logic [TIME_W-1:0] time_o,
  input logic              ovf_o,
  input logic              valid_o
);
  localparam logic [CODE_W-1:0] CodeMax = {CODE_W{1'b1}};

  p_start_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(charge_en_o) |-> $past(gate_i));

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(charge_en_o && discharge_en_o));

  p_disch_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(discharge_en_o) |-> (valid_o && !$past(cap_pos_i)));

  p_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (code_o == CodeMax));

  p_time_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (time_o == TIME_W'(code_o) * TIME_W'(STEP_Q)));

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(code_o) && $stable(ovf_o)));

  p_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(charge_en_o) |-> !$past(cap_pos_i, 2));
endmodule

bind dual_slope_tdc dstdc_checker #(
  .CODE_W(CODE_W),
  .STEP_W(STEP_W),
  .STEP_Q(STEP_Q)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .gate_i        (gate_i),
  .cap_pos_i     (cap_pos_i),
  .charge_en_o   (charge_en_o),
  .discharge_en_o(discharge_en_o),
  .code_o        (code_o),
  .time_o        (time_o),
  .ovf_o         (ovf_o),
  .valid_o       (valid_o)
);

// File: tb/tb_dual_slope_tdc.sv
module tb_dual_slope_tdc;
  localparam int CODE_W = 4;
  localparam int STEP_W = 16;
  localparam int TIME_W = CODE_W + STEP_W;
  localparam int STEP   = 1646;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate = 1'b0;
  logic cap_pos;
  logic charge_en, discharge_en, ovf, valid;
  logic [CODE_W-1:0] code;
  logic [TIME_W-1:0] tval;

  int checks = 0;
  int errors = 0;

  // behavioural integrator
  int ich = 413, idis = 85;
  int vcap = 0;
  bit force_hi = 1'b0;
  int n_ch = 0, n_dis = 0;

  always #10 clk = ~clk;

  assign cap_pos = force_hi || (vcap > 0);

  dual_slope_tdc dut (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .cap_pos_i(cap_pos),
    .charge_en_o(charge_en), .discharge_en_o(discharge_en),
    .code_o(code), .time_o(tval), .ovf_o(ovf), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (charge_en && discharge_en)
        chk(1'b0, "R3 both enables", 1, 0);
      if (charge_en) begin
        vcap = vcap + ich;
        n_ch++;
      end
      if (discharge_en) begin
        vcap = (vcap > idis) ? vcap - idis : 0;
        n_dis++;
      end
    end
  end

  function automatic int exp_raw(input int g, input int ic, input int id);
    return (g * ic + id - 1) / id - 1;
  endfunction

  task automatic measure(input int g, input int ic, input int id);
    int raw, ec, t;
    bit got;
    ich = ic; idis = id;
    n_ch = 0; n_dis = 0;
    raw = exp_raw(g, ic, id);
    ec  = (raw > MAXC) ? MAXC : raw;
    @(negedge clk);
    gate = 1'b1;
    repeat (g) @(negedge clk);
    gate = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (valid) begin got = 1'b1; break; end
    end
    chk(got, "R7 valid seen", int'(got), 1);
    chk(n_ch == g, "R2 charge cycles", n_ch, g);
    chk(n_dis == raw + 1, "R4 discharge cycles", n_dis, raw + 1);
    chk(int'(code) == ec, "R4 code", int'(code), ec);
    chk(ovf == (raw > MAXC), "R5 overflow flag", int'(ovf), int'(raw > MAXC));
    chk(int'(tval) == ec * STEP, "R6 time estimate", int'(tval), ec * STEP);
    t = int'(code);
    @(negedge clk);
    chk(!valid, "R7 single strobe", int'(valid), 0);
    repeat (3) @(negedge clk);
    chk(int'(code) == t && !valid, "R7 hold", int'(code), t);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #1;
    chk(!charge_en && !discharge_en, "R1 enables in reset", int'(charge_en), 0);
    chk(!valid && code == 0 && tval == 0 && !ovf, "R1 outputs in reset", int'(code), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && code == 0 && !charge_en, "R1 after reset", int'(code), 0);
    @(negedge clk);

    measure(2, 413, 85);     // 9
    measure(3, 413, 85);     // 14
    measure(1, 413, 85);     // 4
    measure(1, 1600, 100);   // exactly 15, no overflow (R5)
    measure(1, 1601, 100);   // 16 -> saturate (R5)
    measure(8, 413, 85);     // deep overflow
    measure(1, 50, 85);      // code 0

    // R8: comparator held high in idle, gate ignored
    force_hi = 1'b1;
    repeat (2) @(negedge clk);
    gate = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!charge_en && !discharge_en, "R8 gate ignored", int'(charge_en), 0);
    end
    gate = 1'b0;
    @(negedge clk);
    chk(!valid, "R8 no result", int'(valid), 0);
    force_hi = 1'b0;
    repeat (2) @(negedge clk);
    measure(2, 413, 85);

    for (int k = 0; k < 40; k++) begin
      int g, ic, id;
      g  = 1 + int'($urandom % 6);
      ic = 200 + int'($urandom % 300);
      id = 60 + int'($urandom % 80);
      repeat (int'($urandom % 3)) @(negedge clk);
      measure(g, ic, id);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule